// File: doc/BRIEF.md
# Precision-time event timestamp queue

This block records the moment at which precision-time event messages cross the line, in two separate queues: one for frames leaving the port (egress) and one for frames arriving (ingress). A frame parser elsewhere pulses a capture strobe for a direction, together with the 4-bit message type and the 16-bit sequence identifier of the frame. When that message type is enabled for that direction, the block takes the time of day presented on its time inputs and appends an entry (seconds, nanoseconds, sequence identifier) to that direction's queue.

Software drains the queues through a small register port. It reads the head entry's time as 16-bit halves, then reads the head's sequence identifier, and that read also removes the entry. Per-direction entry counts, sticky "entries waiting" and "entry lost" flags, a read-to-clear status register and a masked interrupt line let a driver service the block from an interrupt handler. A control write empties both queues at once.

Top module: `ts_capture_unit`

## Requirements
- R1: After reset, both queues are empty, the count register reads 0, the status register reads 0, both type-enable registers and the interrupt enable register read 0, and `ts_irq` is low.
- R2: A capture strobe adds an entry only when its message type is 0..3 and bit `type` of that direction's type-enable register is set (bit 0 Sync, bit 1 Delay request, bit 2 Peer delay request, bit 3 Peer delay response); types 4..15 are never recorded.
- R3: Register map on the 4-bit address: 0 interrupt enable, 1 interrupt status, 2 counts, 3 control, 4 egress type enable, 5 ingress type enable, 6..10 egress head and 11..15 ingress head, each head group ordered seconds[31:16], seconds[15:0], {2'b00, ns[29:16]}, ns[15:0], sequence id. Read data appears on `cfg_rdata` the cycle after `cfg_rd`; head fields hold the time inputs and sequence id of the capture cycle, and reading the four time fields removes nothing.
- R4: Reading a direction's sequence-id address returns the head's sequence id and removes that entry, so entries leave in capture order; on an empty queue every head field reads 0 and the read changes nothing.
- R5: The count register holds the egress entry count in bits 11:8 and the ingress entry count in bits 3:0, with all other bits 0.
- R6: Each queue holds 8 entries; an enabled capture into a full queue is discarded, leaves the stored entries and count unchanged, and sets that direction's overflow status bit.
- R7: Status bits: 0 ingress entries waiting, 1 ingress overflow, 2 egress entries waiting, 3 egress overflow. Reading the status register returns it and clears all bits; a waiting bit stays set once its queue holds an entry (even after draining) and sets again the cycle after a clear if entries remain.
- R8: `ts_irq` is high exactly when some status bit is set whose interrupt-enable bit (same bit position) is set.
- R9: Writing the control register with bit 0 set empties both queues and clears the status register, leaving the enable registers unchanged.
- R10: The two directions are independent: captures, removals and overflow in one direction leave the other direction's entries, count and status bits as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tod_sec | input | 32 | Current time, seconds |
| tod_ns | input | 30 | Current time, nanoseconds |
| egr_stb | input | 1 | Egress capture strobe |
| egr_msg_type | input | 4 | Egress message type |
| egr_seq_id | input | 16 | Egress sequence identifier |
| ing_stb | input | 1 | Ingress capture strobe |
| ing_msg_type | input | 4 | Ingress message type |
| ing_seq_id | input | 16 | Ingress sequence identifier |
| cfg_addr | input | 4 | Register address |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe (read side effects occur here) |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data, valid the cycle after `cfg_rd` |
| ts_irq | output | 1 | Masked interrupt |

## Verification
The embedded properties watch, on every cycle, that no entry is written into a full queue, that a lost capture always coincides with a full queue that then stays full, that types outside the four event types never reach a queue, that a removal lowers the count by one, that a lost capture raises the sticky overflow bit and that a status read or control flush clears what it should. What only the bench scenarios can show is the data path: that the right time and sequence id come back in capture order, that head halves are split at the right bit, that counts land in the right register nibbles, that the two directions never disturb each other and that the masked interrupt follows the status exactly over long random mixes of captures, reads and enable changes.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;

  localparam int SEC_W   = 32;
  localparam int NS_W    = 30;
  localparam int SEQ_W   = 16;
  localparam int MSG_W   = 4;
  localparam int N_TYPES = 4;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 4;
  localparam int N_DIR   = 2;
  localparam int STS_W   = 2 * N_DIR;

  localparam int DIR_IN = 0;
  localparam int DIR_EG = 1;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
    logic [SEQ_W-1:0] seq;
  } ts_entry_t;

  // register addresses
  localparam logic [ADDR_W-1:0] A_IRQ_EN  = 4'd0;
  localparam logic [ADDR_W-1:0] A_IRQ_STS = 4'd1;
  localparam logic [ADDR_W-1:0] A_COUNT   = 4'd2;
  localparam logic [ADDR_W-1:0] A_CTRL    = 4'd3;
  localparam logic [ADDR_W-1:0] A_EG_ENA  = 4'd4;
  localparam logic [ADDR_W-1:0] A_IN_ENA  = 4'd5;
  localparam logic [ADDR_W-1:0] A_EG_HEAD = 4'd6;
  localparam logic [ADDR_W-1:0] A_IN_HEAD = 4'd11;
  localparam logic [ADDR_W-1:0] SEQ_OFS   = 4'd4;

  // capture gate: only the four event types, each with its own enable
  function automatic logic type_enabled(input logic [N_TYPES-1:0] ena,
                                        input logic [MSG_W-1:0]   msg);
    if (msg >= MSG_W'(N_TYPES)) return 1'b0;
    return ena[msg[1:0]];
  endfunction

  // one 16-bit view of a head entry, selected by offset within its group
  function automatic logic [REG_W-1:0] head_field(input ts_entry_t e,
                                                  input logic [2:0] ofs);
    case (ofs)
      3'd0:    return e.sec[31:16];
      3'd1:    return e.sec[15:0];
      3'd2:    return {2'b00, e.ns[29:16]};
      3'd3:    return e.ns[15:0];
      3'd4:    return e.seq;
      default: return '0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] pack_counts(input logic [3:0] in_c,
                                                   input logic [3:0] eg_c);
    return {4'b0000, eg_c, 4'b0000, in_c};
  endfunction

  function automatic logic irq_any(input logic [STS_W-1:0] sts,
                                   input logic [STS_W-1:0] en);
    return |(sts & en);
  endfunction

endpackage

// File: rtl/ts_fifo.sv
module ts_fifo
  import ts_cap_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  ts_entry_t     din,
  input  logic          pop,
  output ts_entry_t     head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  ts_entry_t     mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= din;
  end

  // the direction logic must never offer an entry to a full queue
  assert_push_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  assert_pop_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push && !flush) |=> count == $past(count) - CW'(1));

  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

endmodule

// File: rtl/ts_dir.sv
module ts_dir
  import ts_cap_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               stb,
  input  logic [MSG_W-1:0]   msg,
  input  logic [SEQ_W-1:0]   seq,
  input  logic [SEC_W-1:0]   now_sec,
  input  logic [NS_W-1:0]    now_ns,
  input  logic [N_TYPES-1:0] ena,
  input  logic               pop,
  output ts_entry_t          head,
  output logic [CW-1:0]      count,
  output logic               push_evt,
  output logic               ovf_evt,
  output logic               nonempty
);

  ts_entry_t entry_in, head_raw;
  logic      accept, full, empty;

  assign accept   = stb && type_enabled(ena, msg);
  assign push_evt = accept && !full;
  assign ovf_evt  = accept && full;
  assign nonempty = !empty;
  assign head     = empty ? '0 : head_raw;

  always_comb begin
    entry_in.sec = now_sec;
    entry_in.ns  = now_ns;
    entry_in.seq = seq;
  end

  ts_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (push_evt),
    .din   (entry_in),
    .pop   (pop),
    .head  (head_raw),
    .count (count),
    .full  (full),
    .empty (empty)
  );

  assert_type_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && msg >= MSG_W'(N_TYPES)) |-> (!push_evt && !ovf_evt));

  assert_ovf_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> count == CW'(DEPTH));

  assert_ovf_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !pop && !flush) |=> count == CW'(DEPTH));

endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit
  import ts_cap_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] tod_sec,
  input  logic [29:0] tod_ns,
  input  logic        egr_stb,
  input  logic [3:0]  egr_msg_type,
  input  logic [15:0] egr_seq_id,
  input  logic        ing_stb,
  input  logic [3:0]  ing_msg_type,
  input  logic [15:0] ing_seq_id,
  input  logic [3:0]  cfg_addr,
  input  logic        cfg_wr,
  input  logic        cfg_rd,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  output logic        ts_irq
);

  logic [N_DIR-1:0]              stb_v, pop_v, push_v, ovf_v, nonempty_v;
  logic [MSG_W-1:0]              msg_v [N_DIR];
  logic [SEQ_W-1:0]              seq_v [N_DIR];
  ts_entry_t                     head_v [N_DIR];
  logic [CW-1:0]                 cnt_v [N_DIR];
  logic [3:0]                    cnt_nib [N_DIR];
  logic [N_DIR-1:0][N_TYPES-1:0] ena_q;
  logic [STS_W-1:0]              ien_q, sts_q;
  logic                          sts_clr, flush;
  logic [REG_W-1:0]              rd_mux;
  logic                          wdata_unused;

  assign stb_v[DIR_IN] = ing_stb;
  assign stb_v[DIR_EG] = egr_stb;
  assign msg_v[DIR_IN] = ing_msg_type;
  assign msg_v[DIR_EG] = egr_msg_type;
  assign seq_v[DIR_IN] = ing_seq_id;
  assign seq_v[DIR_EG] = egr_seq_id;

  assign sts_clr      = cfg_rd && (cfg_addr == A_IRQ_STS);
  assign flush        = cfg_wr && (cfg_addr == A_CTRL) && cfg_wdata[0];
  assign wdata_unused = ^cfg_wdata[REG_W-1:STS_W];

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    localparam logic [ADDR_W-1:0] BASE = (d == DIR_EG) ? A_EG_HEAD : A_IN_HEAD;

    assign pop_v[d]   = cfg_rd && (cfg_addr == ADDR_W'(BASE + SEQ_OFS));
    assign cnt_nib[d] = 4'(cnt_v[d]);

    ts_dir #(.DEPTH(DEPTH)) u_dir (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .stb      (stb_v[d]),
      .msg      (msg_v[d]),
      .seq      (seq_v[d]),
      .now_sec  (tod_sec),
      .now_ns   (tod_ns),
      .ena      (ena_q[d]),
      .pop      (pop_v[d]),
      .head     (head_v[d]),
      .count    (cnt_v[d]),
      .push_evt (push_v[d]),
      .ovf_evt  (ovf_v[d]),
      .nonempty (nonempty_v[d])
    );
  end

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      ena_q <= '0;
    end else if (cfg_wr) begin
      case (cfg_addr)
        A_IRQ_EN: ien_q         <= cfg_wdata[STS_W-1:0];
        A_EG_ENA: ena_q[DIR_EG] <= cfg_wdata[N_TYPES-1:0];
        A_IN_ENA: ena_q[DIR_IN] <= cfg_wdata[N_TYPES-1:0];
        default:  ;
      endcase
    end
  end

  // status: waiting bits track occupancy, overflow bits are sticky
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else if (flush) begin
      sts_q <= '0;
    end else begin
      for (int d = 0; d < N_DIR; d++) begin
        sts_q[2*d]   <= (sts_q[2*d] & ~sts_clr) | push_v[d] | (nonempty_v[d] & ~sts_clr);
        sts_q[2*d+1] <= (sts_q[2*d+1] & ~sts_clr) | ovf_v[d];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (cfg_addr)
      A_IRQ_EN:  rd_mux = REG_W'(ien_q);
      A_IRQ_STS: rd_mux = REG_W'(sts_q);
      A_COUNT:   rd_mux = pack_counts(cnt_nib[DIR_IN], cnt_nib[DIR_EG]);
      A_CTRL:    rd_mux = '0;
      A_EG_ENA:  rd_mux = REG_W'(ena_q[DIR_EG]);
      A_IN_ENA:  rd_mux = REG_W'(ena_q[DIR_IN]);
      default: begin
        if (cfg_addr >= A_IN_HEAD)
          rd_mux = head_field(head_v[DIR_IN], 3'(cfg_addr - A_IN_HEAD));
        else
          rd_mux = head_field(head_v[DIR_EG], 3'(cfg_addr - A_EG_HEAD));
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_mux;
  end

  assign ts_irq = irq_any(sts_q, ien_q);

  assert_ovf_sticky_in_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_v[DIR_IN] && !flush) |=> sts_q[1]);

  assert_ovf_sticky_eg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_v[DIR_EG] && !flush) |=> sts_q[3]);

  assert_sts_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !ovf_v[DIR_EG] && !ovf_v[DIR_IN]) |=> (!sts_q[1] && !sts_q[3]));

  assert_avail_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nonempty_v[DIR_IN] && !sts_clr && !flush) |=> sts_q[0]);

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !ts_irq);

  assert_flush_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (sts_q == '0));

endmodule

// File: tb/ts_capture_unit_test.sv
`timescale 1ns/1ps
module ts_capture_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tod_sec = '0;
  logic [29:0] tod_ns = '0;
  logic        egr_stb = 1'b0, ing_stb = 1'b0;
  logic [3:0]  egr_msg_type = '0, ing_msg_type = '0;
  logic [15:0] egr_seq_id = '0, ing_seq_id = '0;
  logic [3:0]  cfg_addr = '0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        ts_irq;

  int n_chk = 0;
  int n_fail = 0;

  // reference model: index 0 ingress, 1 egress
  logic [77:0] mq [0:1][0:7];
  int          mcnt [0:1];
  logic [3:0]  mena [0:1];
  logic [3:0]  mien;
  logic        mav [0:1];
  logic        mov [0:1];

  always #2.5 clk = ~clk;

  ts_capture_unit uut (
    .clk(clk), .rst_n(rst_n), .tod_sec(tod_sec), .tod_ns(tod_ns),
    .egr_stb(egr_stb), .egr_msg_type(egr_msg_type), .egr_seq_id(egr_seq_id),
    .ing_stb(ing_stb), .ing_msg_type(ing_msg_type), .ing_seq_id(ing_seq_id),
    .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ts_irq(ts_irq)
  );

  function automatic logic [15:0] fld(input logic [77:0] e, input int ofs);
    case (ofs)
      0: return e[77:62];
      1: return e[61:46];
      2: return {2'b00, e[45:32]};
      3: return e[31:16];
      default: return e[15:0];
    endcase
  endfunction

  function automatic int head_addr(input int d, input int ofs);
    return (d == 1) ? 6 + ofs : 11 + ofs;
  endfunction

  function automatic logic [3:0] exp_sts();
    return {mov[1], mav[1], mov[0], mav[0]};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_read(input int a, output logic [15:0] v);
    cfg_addr = 4'(a);
    cfg_rd = 1'b1;
    @(negedge clk);
    v = cfg_rdata;
    cfg_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_write(input int a, input logic [15:0] v);
    cfg_addr = 4'(a);
    cfg_wdata = v;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic model_push(input int d, input logic [3:0] msg, input logic [15:0] seq,
                            input logic [31:0] sec, input logic [29:0] ns);
    if (msg < 4 && mena[d][msg[1:0]]) begin
      if (mcnt[d] == 8) mov[d] = 1'b1;
      else begin
        mq[d][mcnt[d]] = {sec, ns, seq};
        mcnt[d]++;
      end
    end
    if (mcnt[d] != 0) mav[d] = 1'b1;
  endtask

  task automatic capture(input bit di, input bit de, input logic [3:0] mi,
                         input logic [3:0] me, input logic [15:0] si, input logic [15:0] se);
    logic [31:0] sec;
    logic [29:0] ns;
    sec = $urandom;
    ns  = 30'($urandom);
    tod_sec = sec; tod_ns = ns;
    ing_stb = di; ing_msg_type = mi; ing_seq_id = si;
    egr_stb = de; egr_msg_type = me; egr_seq_id = se;
    @(negedge clk);
    ing_stb = 1'b0; egr_stb = 1'b0;
    tod_sec = $urandom; tod_ns = 30'($urandom);
    @(negedge clk);
    if (di) model_push(0, mi, si, sec, ns);
    if (de) model_push(1, me, se, sec, ns);
  endtask

  task automatic read_head(input int d, input int ofs, input string req);
    logic [15:0] v, e;
    do_read(head_addr(d, ofs), v);
    e = (mcnt[d] != 0) ? fld(mq[d][0], ofs) : 16'h0;
    chk(req, (d == 1) ? "egress head field" : "ingress head field", v, e);
    if (ofs == 4 && mcnt[d] != 0) begin
      for (int i = 0; i < 7; i++) mq[d][i] = mq[d][i+1];
      mcnt[d]--;
    end
  endtask

  task automatic read_counts(input string req);
    logic [15:0] v;
    do_read(2, v);
    chk(req, "count register", v, {4'h0, 4'(mcnt[1]), 4'h0, 4'(mcnt[0])});
  endtask

  task automatic read_sts(input string req);
    logic [15:0] v;
    do_read(1, v);
    chk(req, "status register", v, {12'h0, exp_sts()});
    for (int d = 0; d < 2; d++) begin
      mov[d] = 1'b0;
      mav[d] = (mcnt[d] != 0);
    end
  endtask

  task automatic check_irq(input string req);
    chk(req, "interrupt line", ts_irq, |(exp_sts() & mien));
  endtask

  task automatic set_ena(input int d, input logic [3:0] v);
    do_write((d == 1) ? 4 : 5, {12'h0, v});
    mena[d] = v;
  endtask

  task automatic set_ien(input logic [3:0] v);
    do_write(0, {12'h0, v});
    mien = v;
  endtask

  task automatic soft_reset();
    do_write(3, 16'h0001);
    for (int d = 0; d < 2; d++) begin
      mcnt[d] = 0; mav[d] = 1'b0; mov[d] = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd7351));
    for (int d = 0; d < 2; d++) begin
      mcnt[d] = 0; mena[d] = 4'h0; mav[d] = 1'b0; mov[d] = 1'b0;
    end
    mien = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    read_counts("R1");
    read_sts("R1");
    do_read(0, v); chk("R1", "irq enable", v, 16'h0);
    do_read(4, v); chk("R1", "egress enable", v, 16'h0);
    do_read(5, v); chk("R1", "ingress enable", v, 16'h0);
    check_irq("R1");

    // R2: nothing recorded while all types disabled
    capture(1, 1, 4'd0, 4'd3, 16'h1111, 16'h2222);
    read_counts("R2");

    // R2: only enabled types, never types above 3
    set_ena(0, 4'b0101);
    capture(1, 0, 4'd0, 4'd0, 16'hA001, 16'h0);
    capture(1, 0, 4'd1, 4'd0, 16'hA002, 16'h0);
    capture(1, 0, 4'd2, 4'd0, 16'hA003, 16'h0);
    capture(1, 0, 4'd8, 4'd0, 16'hA004, 16'h0);
    read_counts("R2");

    // R3/R4: halves do not remove, sequence read removes in order
    for (int o = 0; o < 4; o++) read_head(0, o, "R3");
    read_counts("R3");
    read_head(0, 4, "R4");
    read_counts("R4");
    read_head(0, 4, "R4");
    read_head(0, 4, "R4");
    read_head(0, 0, "R4");
    read_counts("R4");

    // R6/R10: fill egress past capacity, ingress untouched
    set_ena(1, 4'b1111);
    capture(1, 0, 4'd0, 4'd0, 16'hB000, 16'h0);
    for (int i = 0; i < 9; i++) capture(0, 1, 4'd0, 4'(i % 4), 16'h0, 16'(16'hC000 + i));
    read_counts("R6");
    read_head(1, 4, "R6");
    read_head(0, 4, "R10");

    // R7/R8
    set_ien(4'b1000);
    check_irq("R8");
    read_sts("R7");
    check_irq("R8");
    read_sts("R7");
    set_ien(4'b0100);
    check_irq("R8");

    // R9: flush keeps enables
    soft_reset();
    read_counts("R9");
    read_sts("R9");
    do_read(4, v); chk("R9", "egress enable kept", v, 16'h000F);
    check_irq("R9");

    // random mix
    for (int k = 0; k < 600; k++) begin
      int op, d;
      op = $urandom % 10;
      d  = $urandom % 2;
      case (op)
        0, 1, 2: begin
          int w;
          w = $urandom % 3;
          capture(w != 1, w != 0, 4'($urandom % 6), 4'($urandom % 6),
                  16'($urandom), 16'($urandom));
        end
        3, 4: read_head(d, 4, "R10");
        5:    read_head(d, $urandom % 4, "R3");
        6:    read_counts("R5");
        7:    read_sts("R7");
        8:    if ($urandom % 2 == 0) set_ena(d, 4'($urandom)); else set_ien(4'($urandom));
        default: if ($urandom % 8 == 0) soft_reset(); else read_counts("R5");
      endcase
      check_irq("R8");
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule